// File: doc/BRIEF.md
# Mesh X-Y Cut-Through Router Node

This block is a single switching node for a two-dimensional mesh without wraparound links. It has five streaming ports, each with an input and an output side: the attached processing element (local), and the neighbours towards north, south, east and west. A message is a sequence of flits. The first flit names the destination column and row. All later flits of the message carry only data and follow the path set by the first flit. The node's own column and row, the mesh dimensions, the payload width and the input buffer depth are parameters.

Routing is deterministic and minimal. A message first moves along X until its column matches the destination column, then along Y until its row matches, and is then delivered to the local port. Because every hop is productive, the hop count from source (Sx,Sy) to destination (Dx,Dy) is |Sx-Dx| + |Sy-Dy|. Flits are forwarded as they arrive. The node never waits for a whole message, and each input holds only a few flits. An output that has accepted a message's first flit stays bound to that input until the last flit of the message has passed.

Every stream port uses valid/ready. A flit moves on a rising clock edge where both valid and ready are high. Once an output raises valid, it keeps valid and the flit unchanged until ready is seen. An input lowers ready only when its buffer is full, so a sender stalled by a busy or blocked output simply holds its flit.

Top module: `mesh_xy_router`

## Requirements
- R1: While reset (rst_n low, asynchronous) is active and on the first edge after its release, every out_valid bit is 0 and every in_ready bit is 1.
- R2: Port slots are 0 local, 1 north (increasing Y), 2 south, 3 east (increasing X), 4 west. A flit's kind is in its top two bits (00 opens a message, 01 middle, 10 closes, 11 whole message in one flit), followed by destination Y, destination X and then the payload in the low bits. An opening flit whose destination X is greater than the node's X leaves east, and one whose X is smaller leaves west, whatever its Y.
- R3: An opening flit whose destination X equals the node's X leaves north if its Y is greater than the node's Y, and south if its Y is smaller.
- R4: An opening flit whose destination equals the node's own coordinates leaves on the local port.
- R5: Middle and closing flits (kinds 01 and 10) follow their message's opening flit to the same output in order, and their destination fields are ignored.
- R6: Once an output carries an opening flit of kind 00, it serves only that input until the closing flit has passed. Messages from other inputs headed there wait, even while the owning input pauses.
- R7: When several inputs ask for the same free output in the same cycle, grants rotate round-robin, starting after the input granted last (slot 0 first after reset).
- R8: A stalled output keeps out_valid high and out_flit stable until out_ready. A blocked input buffers BUF_DEPTH flits, then drops in_ready, and loses no flit.
- R9: An opening flit accepted in cycle A appears on its output in cycle A+2. Streaming flits pass through while later flits still arrive, so a message's last flit leaves one cycle after it is accepted.
- R10: Messages between different input/output pairs proceed at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per-slot input flit valid |
| in_flit | input | 5*FW | Input flits, slot s at bits [s*FW +: FW] (FW = 2+YW+XW+PAYLOAD_W) |
| in_ready | output | 5 | Per-slot input ready (buffer not full) |
| out_valid | output | 5 | Per-slot output flit valid |
| out_flit | output | 5*FW | Output flits, slot s at bits [s*FW +: FW] |
| out_ready | input | 5 | Per-slot downstream ready |

## Verification
Two situations are hard to reach from the ports. The first is a second input asking for an output that is already bound to a message whose sender has paused. The bench sends an opening flit from the west, leaves the west input idle for several cycles, and injects a competing single-flit message from the local port during that gap. It then checks that the competitor only appears after the closing flit. The second is a full input buffer behind a stalled output. The bench holds one out_ready low long enough to fill the west buffer, and checks that in_ready falls and that the waiting flit stays stable. The round-robin order is checked by having three inputs queue two messages each for the east port in the same cycle.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;

  localparam int NUM_PORTS = 5;

  // Port slot numbering; the bench and the brief rely on these values.
  typedef enum logic [2:0] {
    SLOT_LOCAL = 3'd0,
    SLOT_NORTH = 3'd1,
    SLOT_SOUTH = 3'd2,
    SLOT_EAST  = 3'd3,
    SLOT_WEST  = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    FK_OPEN   = 2'b00,
    FK_MIDDLE = 2'b01,
    FK_CLOSE  = 2'b10,
    FK_WHOLE  = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(input logic [1:0] kind);
    return (kind == FK_OPEN) || (kind == FK_WHOLE);
  endfunction

  function automatic logic kind_closes(input logic [1:0] kind);
    return (kind == FK_CLOSE) || (kind == FK_WHOLE);
  endfunction

endpackage

// File: rtl/flit_buffer.sv
module flit_buffer #(
  parameter int W     = 14,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/xy_route_sel.sv
module xy_route_sel
  import mesh_rt_pkg::*;
#(
  parameter int XW     = 2,
  parameter int YW     = 2,
  parameter int NODE_X = 1,
  parameter int NODE_Y = 1
) (
  input  logic [XW-1:0]        dest_x,
  input  logic [YW-1:0]        dest_y,
  output logic [NUM_PORTS-1:0] dir
);

  // X is resolved completely before Y is looked at.
  always_comb begin
    dir = '0;
    if (dest_x > XW'(NODE_X))      dir[SLOT_EAST]  = 1'b1;
    else if (dest_x < XW'(NODE_X)) dir[SLOT_WEST]  = 1'b1;
    else if (dest_y > YW'(NODE_Y)) dir[SLOT_NORTH] = 1'b1;
    else if (dest_y < YW'(NODE_Y)) dir[SLOT_SOUTH] = 1'b1;
    else                           dir[SLOT_LOCAL] = 1'b1;
  end

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         take,
  output logic [N-1:0] grant
);

  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last_q;
  logic [PW-1:0] win;
  logic          found;

  // Search starts one past the last winner and wraps.
  always_comb begin
    grant = '0;
    win   = last_q;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[(int'(last_q) + k) % N]) begin
        found = 1'b1;
        grant[(int'(last_q) + k) % N] = 1'b1;
        win = PW'((int'(last_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= PW'(N - 1);
    else if (take) last_q <= win;
  end

endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router
  import mesh_rt_pkg::*;
#(
  parameter int MESH_X    = 4,
  parameter int MESH_Y    = 4,
  parameter int NODE_X    = 1,
  parameter int NODE_Y    = 1,
  parameter int PAYLOAD_W = 8,
  parameter int BUF_DEPTH = 2,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  localparam int FW = 2 + YW + XW + PAYLOAD_W,
  localparam int NP = NUM_PORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*FW-1:0] in_flit,
  output logic [NP-1:0]    in_ready,
  output logic [NP-1:0]    out_valid,
  output logic [NP*FW-1:0] out_flit,
  input  logic [NP-1:0]    out_ready
);

  localparam int IW = $clog2(NP);

  logic [FW-1:0] head      [NP];
  logic [NP-1:0] head_v, buf_full, pop, opens, req_in, connected;
  logic [NP-1:0] route_oh  [NP];
  logic          busy_q    [NP];
  logic [IW-1:0] owner_q   [NP];
  logic [NP-1:0] arb_req   [NP];
  logic [NP-1:0] grant     [NP];
  logic [IW-1:0] gidx      [NP];
  logic [FW-1:0] sel_flit  [NP];
  logic [NP-1:0] sel_v, take, xfer, last_out;

  // ---------------- input side ----------------
  for (genvar i = 0; i < NP; i++) begin : g_in
    flit_buffer #(.W(FW), .DEPTH(BUF_DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i]),
      .din   (in_flit[i*FW +: FW]),
      .pop   (pop[i]),
      .dout  (head[i]),
      .valid (head_v[i]),
      .full  (buf_full[i])
    );

    xy_route_sel #(.XW(XW), .YW(YW), .NODE_X(NODE_X), .NODE_Y(NODE_Y)) u_route (
      .dest_x (head[i][PAYLOAD_W +: XW]),
      .dest_y (head[i][PAYLOAD_W + XW +: YW]),
      .dir    (route_oh[i])
    );

    assign in_ready[i] = ~buf_full[i];
    assign opens[i]    = kind_opens(head[i][FW-1 -: 2]);
    assign req_in[i]   = head_v[i] & opens[i] & ~connected[i];
  end

  // Which input is bound to an output, and whether its head leaves now.
  always_comb begin
    connected = '0;
    pop       = '0;
    for (int o = 0; o < NP; o++) begin
      if (busy_q[o]) begin
        for (int i = 0; i < NP; i++) begin
          if (owner_q[o] == IW'(i)) begin
            connected[i] = 1'b1;
            pop[i]       = xfer[o];
          end
        end
      end
    end
  end

  // ---------------- output side ----------------
  for (genvar o = 0; o < NP; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < NP; i++) arb_req[o][i] = req_in[i] & route_oh[i][o];
    end

    assign take[o] = ~busy_q[o] & (|arb_req[o]);

    rr_arbiter #(.N(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (arb_req[o]),
      .take  (take[o]),
      .grant (grant[o])
    );

    always_comb begin
      gidx[o] = '0;
      for (int i = 0; i < NP; i++) begin
        if (grant[o][i]) gidx[o] = IW'(i);
      end
    end

    always_comb begin
      sel_flit[o] = '0;
      sel_v[o]    = 1'b0;
      for (int i = 0; i < NP; i++) begin
        if (owner_q[o] == IW'(i)) begin
          sel_flit[o] = head[i];
          sel_v[o]    = head_v[i];
        end
      end
    end

    assign out_valid[o]            = busy_q[o] & sel_v[o];
    assign out_flit[o*FW +: FW]    = sel_flit[o];
    assign xfer[o]                 = out_valid[o] & out_ready[o];
    assign last_out[o]             = kind_closes(sel_flit[o][FW-1 -: 2]);

    // Bind on grant, release after the closing flit is taken.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[o]  <= 1'b0;
        owner_q[o] <= '0;
      end else if (take[o]) begin
        busy_q[o]  <= 1'b1;
        owner_q[o] <= gidx[o];
      end else if (xfer[o] && last_out[o]) begin
        busy_q[o]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mesh_xy_router_chk.sv
module mesh_xy_router_chk
  import mesh_rt_pkg::*;
#(
  parameter int MESH_X    = 4,
  parameter int MESH_Y    = 4,
  parameter int NODE_X    = 1,
  parameter int NODE_Y    = 1,
  parameter int PAYLOAD_W = 8,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  localparam int FW = 2 + YW + XW + PAYLOAD_W,
  localparam int NP = NUM_PORTS
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP-1:0]    in_ready,
  input logic [NP-1:0]    out_valid,
  input logic [NP*FW-1:0] out_flit,
  input logic [NP-1:0]    out_ready
);

  logic [FW-1:0] of [NP];
  logic [NP-1:0] hdr;
  logic [XW-1:0] dx [NP];
  logic [YW-1:0] dy [NP];

  for (genvar o = 0; o < NP; o++) begin : g_f
    assign of[o]  = out_flit[o*FW +: FW];
    assign hdr[o] = out_valid[o] && kind_opens(of[o][FW-1 -: 2]);
    assign dx[o]  = of[o][PAYLOAD_W +: XW];
    assign dy[o]  = of[o][PAYLOAD_W + XW +: YW];

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(of[o])); // R8
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0) && (in_ready == '1)); // R1

  AST_EAST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    hdr[SLOT_EAST] |-> dx[SLOT_EAST] > XW'(NODE_X)); // R2

  AST_WEST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    hdr[SLOT_WEST] |-> dx[SLOT_WEST] < XW'(NODE_X)); // R2

  AST_NORTH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    hdr[SLOT_NORTH] |-> dx[SLOT_NORTH] == XW'(NODE_X) && dy[SLOT_NORTH] > YW'(NODE_Y)); // R3

  AST_SOUTH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    hdr[SLOT_SOUTH] |-> dx[SLOT_SOUTH] == XW'(NODE_X) && dy[SLOT_SOUTH] < YW'(NODE_Y)); // R3

  AST_LOCAL_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    hdr[SLOT_LOCAL] |-> dx[SLOT_LOCAL] == XW'(NODE_X) && dy[SLOT_LOCAL] == YW'(NODE_Y)); // R4

endmodule

bind mesh_xy_router mesh_xy_router_chk #(
  .MESH_X(MESH_X), .MESH_Y(MESH_Y), .NODE_X(NODE_X), .NODE_Y(NODE_Y), .PAYLOAD_W(PAYLOAD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_flit(out_flit), .out_ready(out_ready)
);

// File: tb/mesh_xy_router_bench.sv
`timescale 1ns/1ps
module mesh_xy_router_bench;

  localparam int NP = 5;
  localparam int PW = 8;
  localparam int FW = 2 + 2 + 2 + PW;
  localparam int LOC = 0, NOR = 1, SOU = 2, EAS = 3, WES = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP*FW-1:0] in_flit = '0;
  logic [NP-1:0]    in_ready;
  logic [NP-1:0]    out_valid;
  logic [NP*FW-1:0] out_flit;
  logic [NP-1:0]    out_ready = '1;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [FW-1:0] rq [NP][$];
  int            rt [NP][$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mesh_xy_router #(.MESH_X(4), .MESH_Y(4), .NODE_X(1), .NODE_Y(1),
                   .PAYLOAD_W(PW), .BUF_DEPTH(2)) u_mesh_xy_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
    .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
  );

  // Record every completed output handshake, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          rq[o].push_back(out_flit[o*FW +: FW]);
          rt[o].push_back(cyc);
        end
      end
    end
  end

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input int dx, input int dy, input int pl);
    return {k, 2'(dy), 2'(dx), 8'(pl)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_q();
    for (int o = 0; o < NP; o++) begin
      rq[o].delete();
      rt[o].delete();
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Call just after a rising edge; returns the cycle stamp of acceptance.
  task automatic send(input int p, input logic [FW-1:0] f, output int acc);
    in_flit[p*FW +: FW] = f;
    in_valid[p] = 1'b1;
    while (1) begin
      @(negedge clk);
      if (in_ready[p]) begin
        acc = cyc;
        break;
      end
    end
    @(posedge clk);
    #1;
    in_valid[p] = 1'b0;
  endtask

  task automatic send_msg(input int p, input int dx, input int dy, input int n, input int tag,
                          output int hacc, output int tacc);
    int a;
    if (n == 1) begin
      send(p, mk(2'b11, dx, dy, tag), a);
      hacc = a;
      tacc = a;
    end else begin
      send(p, mk(2'b00, dx, dy, tag), a);
      hacc = a;
      for (int j = 1; j < n - 1; j++) send(p, mk(2'b01, 0, 0, tag + j), a);
      send(p, mk(2'b10, 3, 3, tag + n - 1), a);
      tacc = a;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'h0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'h1F);
    idle(1);
  endtask

  task automatic t_routes();
    int dxs [7] = '{3, 0, 1, 1, 1, 3, 0};
    int dys [7] = '{1, 1, 3, 0, 1, 3, 0};
    int exs [7] = '{EAS, WES, NOR, SOU, LOC, EAS, WES};
    int h, t, tot;
    for (int k = 0; k < 7; k++) begin
      clear_q();
      send_msg(LOC, dxs[k], dys[k], 1, 8'h40 + k, h, t);
      idle(6);
      tot = 0;
      for (int o = 0; o < NP; o++) tot += rq[o].size();
      chk("R2/R3/R4 single flit count", 32'(tot), 32'd1);
      if (rq[exs[k]].size() == 1)
        chk(exs[k] == LOC ? "R4 local delivery" : (exs[k] >= EAS ? "R2 X first" : "R3 Y after X"),
            32'(rq[exs[k]][0]), 32'(mk(2'b11, dxs[k], dys[k], 8'h40 + k)));
      else
        chk("R2/R3/R4 expected port", 32'(rq[exs[k]].size()), 32'd1);
    end
  endtask

  task automatic t_message();
    int h, t;
    clear_q();
    send_msg(WES, 3, 2, 4, 8'h20, h, t);
    idle(6);
    chk("R5 flit count on east", 32'(rq[EAS].size()), 32'd4);
    if (rq[EAS].size() == 4) begin
      chk("R5 header", 32'(rq[EAS][0]), 32'(mk(2'b00, 3, 2, 8'h20)));
      chk("R5 middle ignores dest", 32'(rq[EAS][1]), 32'(mk(2'b01, 0, 0, 8'h21)));
      chk("R5 middle 2", 32'(rq[EAS][2]), 32'(mk(2'b01, 0, 0, 8'h22)));
      chk("R5 closing", 32'(rq[EAS][3]), 32'(mk(2'b10, 3, 3, 8'h23)));
    end
  endtask

  task automatic t_latency();
    int h, t;
    clear_q();
    send_msg(LOC, 1, 3, 4, 8'h30, h, t);
    idle(6);
    chk("R9 flit count north", 32'(rq[NOR].size()), 32'd4);
    if (rq[NOR].size() == 4) begin
      chk("R9 header at A+2", 32'(rt[NOR][0]), 32'(h + 2));
      chk("R9 header out before tail in", 32'(rt[NOR][0] < t), 32'd1);
      chk("R9 tail one cycle after accept", 32'(rt[NOR][3]), 32'(t + 1));
    end
  endtask

  task automatic t_lock();
    int h, t, h2, t2, a;
    clear_q();
    fork
      begin
        send(WES, mk(2'b00, 2, 1, 8'h50), a);
        idle(5);
        send(WES, mk(2'b01, 0, 0, 8'h51), a);
        send(WES, mk(2'b10, 0, 0, 8'h52), a);
      end
      begin
        idle(1);
        send_msg(LOC, 3, 0, 1, 8'h60, h2, t2);
      end
    join
    idle(8);
    chk("R6 east count", 32'(rq[EAS].size()), 32'd4);
    if (rq[EAS].size() == 4) begin
      chk("R6 order 0", 32'(rq[EAS][0][7:0]), 32'h50);
      chk("R6 order 1", 32'(rq[EAS][1][7:0]), 32'h51);
      chk("R6 order 2", 32'(rq[EAS][2][7:0]), 32'h52);
      chk("R6 waiter after close", 32'(rq[EAS][3][7:0]), 32'h60);
    end
  endtask

  task automatic t_rr();
    int h0, t0, h1, t1, h2, t2;
    logic [NP-1:0] seen;
    clear_q();
    fork
      begin send_msg(LOC, 2, 2, 1, 8'h10 | (LOC << 1), h0, t0); send_msg(LOC, 2, 2, 1, 8'h11 | (LOC << 1), h0, t0); end
      begin send_msg(NOR, 2, 2, 1, 8'h10 | (NOR << 1), h1, t1); send_msg(NOR, 2, 2, 1, 8'h11 | (NOR << 1), h1, t1); end
      begin send_msg(SOU, 2, 2, 1, 8'h10 | (SOU << 1), h2, t2); send_msg(SOU, 2, 2, 1, 8'h11 | (SOU << 1), h2, t2); end
    join
    idle(12);
    chk("R7 east count", 32'(rq[EAS].size()), 32'd6);
    if (rq[EAS].size() == 6) begin
      for (int r = 0; r < 2; r++) begin
        seen = '0;
        for (int j = 0; j < 3; j++) seen[(rq[EAS][r*3 + j] >> 1) & 7] = 1'b1;
        chk("R7 round distinct sources", 32'(seen), 32'h07);
      end
    end
  endtask

  task automatic t_backpressure();
    int h, t;
    clear_q();
    out_ready[EAS] = 1'b0;
    fork
      send_msg(WES, 3, 1, 4, 8'h70, h, t);
      begin
        idle(8);
        @(negedge clk);
        chk("R8 input stalls when full", 32'(in_ready[WES]), 32'd0);
        chk("R8 valid held", 32'(out_valid[EAS]), 32'd1);
        chk("R8 flit held", 32'(out_flit[EAS*FW +: FW]), 32'(mk(2'b00, 3, 1, 8'h70)));
        idle(3);
        @(negedge clk);
        chk("R8 flit still stable", 32'(out_flit[EAS*FW +: FW]), 32'(mk(2'b00, 3, 1, 8'h70)));
        @(posedge clk);
        #1;
        out_ready[EAS] = 1'b1;
      end
    join
    idle(6);
    chk("R8 no flit lost", 32'(rq[EAS].size()), 32'd4);
    if (rq[EAS].size() == 4) begin
      chk("R8 order after release", 32'(rq[EAS][2][7:0]), 32'h72);
      chk("R8 last after release", 32'(rq[EAS][3][7:0]), 32'h73);
    end
  endtask

  task automatic t_concurrent();
    int h0, t0, h1, t1;
    clear_q();
    fork
      send_msg(WES, 2, 0, 3, 8'h80, h0, t0);
      send_msg(EAS, 0, 3, 3, 8'h90, h1, t1);
    join
    idle(6);
    chk("R10 east count", 32'(rq[EAS].size()), 32'd3);
    chk("R10 west count", 32'(rq[WES].size()), 32'd3);
    if (rq[EAS].size() == 3 && rq[WES].size() == 3)
      chk("R10 parallel header timing", 32'(rt[EAS][0]), 32'(rt[WES][0]));
  endtask

  initial begin
    t_reset();
    t_routes();
    t_message();
    t_latency();
    t_lock();
    t_rr();
    t_backpressure();
    t_concurrent();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule